// File: doc/BRIEF.md
# Phase-Frequency Detector Controller

This block is the digital comparison stage of a PLL synthesiser. It watches two divided clocks, the loop feedback (divided RF) and the divided reference, and commands an external charge pump with `pump_up` and `pump_dn` pulses. Each pulse lasts as many system-clock cycles as the two edges are apart. The tri-state detector is built from two flip-flops. A lock monitor flags when the loop has stayed phase-aligned for a programmable number of reference periods.

A parallel write port loads two control words. Word 0 sets the detector polarity and one of four operating states. The states switch the detector and the monitor outputs on or off, and one of them drives the pump only until lock is reached, so that an external detector can take over. Word 1 carries a two-bit charge-pump gain code, which goes out unchanged to the analog pump. The monitor outputs are copies of the two divided clocks, delayed by one cycle. The polarity bit swaps them together with the detector inputs, so an external detector sees the same sense.

The divided clocks are treated as levels that are synchronous to `clk`, and their rising edges are found by comparing each one with its value on the previous cycle.

Top module: `pfd_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pump_up`, `pump_dn`, `mon_fb`, `mon_ref` and `lock` are 0, `gain_code` is 00, polarity is 0 and the operating state is 00.
- R2: With polarity 0, a feedback rising edge that comes d cycles before the reference rising edge gives `pump_up` high for exactly d cycles. A reference edge that comes d cycles before the feedback edge gives `pump_dn` high for exactly d cycles. Each output goes high on the clock edge that samples its own input edge.
- R3: When both rising edges are sampled on the same cycle, the pulse that was set is cleared at once, so neither `pump_up` nor `pump_dn` pulses.
- R4: With polarity 1, the two inputs swap roles: the reference edge leading by d cycles gives `pump_up` for d cycles, and the feedback edge leading by d cycles gives `pump_dn` for d cycles.
- R5: A new polarity value written while a pump flip-flop is set takes effect only on a cycle when both flip-flops are clear. The pulse in progress ends under the old polarity with no spurious opposite pulse.
- R6: `mon_fb` and `mon_ref` copy `fb_in` and `ref_in` with a one-cycle delay. While the active polarity is 1, `mon_fb` carries the reference and `mon_ref` carries the feedback.
- R7: In state 00 the detector drives the pump and both monitor outputs stay at 0. In state 01 the detector drives the pump and the monitor outputs are on.
- R8: In state 11, `pump_up` and `pump_dn` stay at 0 and the monitor outputs are on.
- R9: In state 10 the detector drives the pump while `lock` is 0 and holds both pump outputs at 0 while `lock` is 1. The monitor outputs are on.
- R10: `lock` rises after LOCK_N reference rising edges with no wide pulse in between. A wide pulse is a pump pulse that stays high for more than WIDE_THR cycles.
- R11: A pump pulse reaching its (WIDE_THR+1)th high cycle clears `lock` and the good-edge count on the next clock edge.
- R12: A write (`wr_en` high) to address 0 loads polarity from bit 12 and the operating state from bits 11:10. A write to address 1 loads `gain_code` from bits 15:14, where 00 selects ×1.0, 01 ×1.5, 10 ×2.5 and 11 ×4.0 pump current. A write to one address leaves the fields of the other unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load strobe for the addressed control word |
| wr_addr | input | 1 | Word select: 0 polarity/state, 1 gain |
| wr_data | input | 16 | Control word data |
| fb_in | input | 1 | Divided RF (feedback) clock, synchronous level |
| ref_in | input | 1 | Divided reference clock, synchronous level |
| pump_up | output | 1 | Charge-pump source command |
| pump_dn | output | 1 | Charge-pump sink command |
| mon_fb | output | 1 | Monitor copy of the feedback clock (swapped by polarity) |
| mon_ref | output | 1 | Monitor copy of the reference clock (swapped by polarity) |
| lock | output | 1 | Phase-lock indication |
| gain_code | output | 2 | Charge-pump current multiplier code |

## Verification
The bench builds the block with WIDE_THR = 2 and LOCK_N = 4. With these values an edge offset of 3 cycles is already a wide pulse, and four clean reference periods are enough to reach lock. This allows a sweep of every edge offset from -4 to +4 in both polarities, each period checked by counting pump-high and monitor-high cycles. It also lets the bench drive lock acquisition, loss on a wide pulse and the hand-off state into the pump gating within a few dozen periods. Directed steps cover a polarity write made in the middle of a pulse and all four gain codes.

// File: rtl/pfd_pkg.sv
// Shared definitions for the phase-frequency detector controller.
// Assumes a 16-bit control word; the field positions are fixed here.
package pfd_pkg;

    localparam int WORD_W    = 16;
    localparam int SENSE_BIT = 12;
    localparam int STATE_LO  = 10;
    localparam int GAIN_LO   = 14;

    // Operating state, encoded as in word 0 bits 11:10
    typedef enum logic [1:0] {
        ST_RUN_QUIET = 2'b00,  // detector on, monitors off
        ST_RUN_MON   = 2'b01,  // detector on, monitors on
        ST_HANDOFF   = 2'b10,  // detector on until lock, monitors on
        ST_OFF       = 2'b11   // detector off, monitors on
    } det_state_t;

endpackage

// File: rtl/pfd_regs.sv
// Control word decode for the detector controller.
// Holds polarity and operating state (address 0) and the gain code
// (address 1). Assumes the writer keeps wr_data stable while wr_en is high.
module pfd_regs
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sense_req,
    output det_state_t        det_state,
    output logic [1:0]        gain_code
);

    logic unused_bits;

    // Bits that no field decodes
    assign unused_bits = ^{wr_data[13], wr_data[STATE_LO-1:0]};

    // Address 0: polarity request and operating state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_req <= 1'b0;
            det_state <= ST_RUN_QUIET;
        end else if (wr_en && !wr_addr) begin
            sense_req <= wr_data[SENSE_BIT];
            det_state <= det_state_t'(wr_data[STATE_LO +: 2]);
        end
    end

    // Address 1: charge-pump gain code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= 2'b00;
        end else if (wr_en && wr_addr) begin
            gain_code <= wr_data[GAIN_LO +: 2];
        end
    end

    a_r12_gain_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> $stable(gain_code));

    a_r12_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> ($stable(sense_req) && $stable(det_state)));

endmodule

// File: rtl/pfd_core.sv
// Tri-state phase-frequency detector with a polarity swap.
// Finds rising edges of the two synchronous divided clocks. Sets an UP or DOWN
// flip-flop on each edge and clears both as soon as both would be set.
// A polarity change is applied only while both flip-flops are clear.
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_in,
    input  logic ref_in,
    input  logic sense_req,
    output logic up_raw,
    output logic dn_raw,
    output logic mon_fb_raw,
    output logic mon_ref_raw,
    output logic ref_rise,
    output logic pulse_active
);

    logic fb_q, ref_q, sense_act;
    logic up_ff, dn_ff;
    logic fb_rise, up_edge, dn_edge, up_nx, dn_nx;

    // Previous-cycle copies of the divided clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q  <= 1'b0;
            ref_q <= 1'b0;
        end else begin
            fb_q  <= fb_in;
            ref_q <= ref_in;
        end
    end

    // Edge detection, polarity routing and the AND-based clear
    always_comb begin
        fb_rise  = fb_in & ~fb_q;
        ref_rise = ref_in & ~ref_q;
        up_edge  = sense_act ? ref_rise : fb_rise;
        dn_edge  = sense_act ? fb_rise  : ref_rise;
        up_nx    = up_ff | up_edge;
        dn_nx    = dn_ff | dn_edge;
        if (up_nx && dn_nx) begin
            up_nx = 1'b0;
            dn_nx = 1'b0;
        end
    end

    // Detector flip-flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_ff <= 1'b0;
            dn_ff <= 1'b0;
        end else begin
            up_ff <= up_nx;
            dn_ff <= dn_nx;
        end
    end

    // Polarity takes the requested value only while both flip-flops are idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_act <= 1'b0;
        end else if (!up_ff && !dn_ff) begin
            sense_act <= sense_req;
        end
    end

    // Outputs towards the gating stage and the lock monitor
    always_comb begin
        up_raw       = up_ff;
        dn_raw       = dn_ff;
        pulse_active = up_ff | dn_ff;
        mon_fb_raw   = sense_act ? ref_q : fb_q;
        mon_ref_raw  = sense_act ? fb_q  : ref_q;
    end

    a_r5_swap_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_act != $past(sense_act)) |-> (!$past(up_ff) && !$past(dn_ff)));

endmodule

// File: rtl/pfd_lock.sv
// Lock monitor. Measures how long each pump pulse stays high and counts
// reference edges seen while no pulse has grown wide. Assumes ref_rise
// is a single-cycle strobe per reference period.
module pfd_lock #(
    parameter int WIDE_THR = 2,
    parameter int LOCK_N   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_active,
    input  logic ref_rise,
    output logic lock
);

    localparam int WW = $clog2(WIDE_THR + 2);
    localparam int CW = $clog2(LOCK_N + 1);
    localparam logic [WW-1:0] W_MAX    = WW'(WIDE_THR);
    localparam logic [CW-1:0] CNT_FULL = CW'(LOCK_N);

    logic [WW-1:0] width_q;
    logic [CW-1:0] good_q;
    logic          wide;

    // Pulse width counter, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (pulse_active) begin
            if (width_q < W_MAX) width_q <= width_q + 1'b1;
        end else begin
            width_q <= '0;
        end
    end

    // A pulse in its (WIDE_THR+1)th high cycle is wide
    assign wide = pulse_active && (width_q >= W_MAX);

    // Good-edge counter: cleared by a wide pulse, saturates at LOCK_N
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (wide) begin
            good_q <= '0;
        end else if (ref_rise && (good_q != CNT_FULL)) begin
            good_q <= good_q + 1'b1;
        end
    end

    assign lock = (good_q == CNT_FULL);

    a_r11_wide_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !lock);

    a_r10_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_rise));

endmodule

// File: rtl/pfd_ctrl.sv
// Programmable phase-frequency detector controller, top level.
// Joins the register decode, the detector core and the lock monitor, and
// gates the pump and monitor outputs by the operating state.
// Assumes fb_in and ref_in are already synchronous to clk.
module pfd_ctrl
    import pfd_pkg::*;
#(
    parameter int WIDE_THR = 2,
    parameter int LOCK_N   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fb_in,
    input  logic              ref_in,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              mon_fb,
    output logic              mon_ref,
    output logic              lock,
    output logic [1:0]        gain_code
);

    logic       sense_req;
    det_state_t det_state;
    logic       up_raw, dn_raw, mon_fb_raw, mon_ref_raw;
    logic       ref_rise, pulse_active;
    logic       drive_en, mon_en;

    pfd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sense_req (sense_req),
        .det_state (det_state),
        .gain_code (gain_code)
    );

    pfd_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .fb_in        (fb_in),
        .ref_in       (ref_in),
        .sense_req    (sense_req),
        .up_raw       (up_raw),
        .dn_raw       (dn_raw),
        .mon_fb_raw   (mon_fb_raw),
        .mon_ref_raw  (mon_ref_raw),
        .ref_rise     (ref_rise),
        .pulse_active (pulse_active)
    );

    pfd_lock #(
        .WIDE_THR (WIDE_THR),
        .LOCK_N   (LOCK_N)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse_active (pulse_active),
        .ref_rise     (ref_rise),
        .lock         (lock)
    );

    // Output gating by operating state
    always_comb begin
        unique case (det_state)
            ST_RUN_QUIET: begin drive_en = 1'b1;  mon_en = 1'b0; end
            ST_RUN_MON:   begin drive_en = 1'b1;  mon_en = 1'b1; end
            ST_HANDOFF:   begin drive_en = !lock; mon_en = 1'b1; end
            default:      begin drive_en = 1'b0;  mon_en = 1'b1; end
        endcase
        pump_up = up_raw & drive_en;
        pump_dn = dn_raw & drive_en;
        mon_fb  = mon_fb_raw & mon_en;
        mon_ref = mon_ref_raw & mon_en;
    end

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == ST_OFF) |-> (!pump_up && !pump_dn));

    a_r7_mon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == ST_RUN_QUIET) |-> (!mon_fb && !mon_ref));

    a_r9_handoff_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == ST_HANDOFF && lock) |-> (!pump_up && !pump_dn));

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

endmodule

// File: tb/pfd_ctrl_bench.sv
module pfd_ctrl_bench;

    localparam int THR  = 2;
    localparam int LCK  = 4;
    localparam int PER  = 16;
    localparam int BASE = 6;
    localparam int HI   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fb_in = 1'b0;
    logic        ref_in = 1'b0;
    logic        pump_up, pump_dn, mon_fb, mon_ref, lock;
    logic [1:0]  gain_code;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pfd_ctrl #(.WIDE_THR(THR), .LOCK_N(LCK)) u_pfd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fb_in(fb_in), .ref_in(ref_in),
        .pump_up(pump_up), .pump_dn(pump_dn), .mon_fb(mon_fb),
        .mon_ref(mon_ref), .lock(lock), .gain_code(gain_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] w0(input int sense, input int st);
        return 16'((sense << 12) | (st << 10));
    endfunction

    // One reference period: ref rises at BASE, feedback at BASE+d
    task automatic run_period(input int d, output int nu, output int nd,
                              output int nmf, output int nmr);
        nu = 0; nd = 0; nmf = 0; nmr = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            nu  += int'(pump_up);
            nd  += int'(pump_dn);
            nmf += int'(mon_fb);
            nmr += int'(mon_ref);
            ref_in = (c >= BASE) && (c < BASE + HI);
            fb_in  = (c >= BASE + d) && (c < BASE + d + HI);
        end
    endtask

    function automatic int exp_up(input int sense, input int d);
        if (d == 0) return 0;
        if (sense == 0) return (d < 0) ? -d : 0;
        return (d > 0) ? d : 0;
    endfunction

    function automatic int exp_dn(input int sense, input int d);
        if (d == 0) return 0;
        if (sense == 0) return (d > 0) ? d : 0;
        return (d < 0) ? -d : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nu, nd, nmf, nmr;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 up", pump_up, 0);   chk("R1 dn", pump_dn, 0);
        chk("R1 monfb", mon_fb, 0); chk("R1 monref", mon_ref, 0);
        chk("R1 lock", lock, 0);    chk("R1 gain", gain_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 state 00: pumps active, monitors quiet (R1: defaults to 00)
        run_period(2, nu, nd, nmf, nmr);
        chk("R7 dn in state 00", nd, 2);
        chk("R7 monfb off", nmf, 0);
        chk("R7 monref off", nmr, 0);

        // R2 R3 R4 sweep of offsets in both polarities, state 01
        for (int s = 0; s < 2; s++) begin
            wr(1'b0, w0(s, 1));
            repeat (2) @(negedge clk);
            for (int d = -4; d <= 4; d++) begin
                run_period(d, nu, nd, nmf, nmr);
                if (d == 0) begin
                    chk("R3 up coincident", nu, 0);
                    chk("R3 dn coincident", nd, 0);
                end else if (s == 0) begin
                    chk("R2 up", nu, exp_up(s, d));
                    chk("R2 dn", nd, exp_dn(s, d));
                end else begin
                    chk("R4 up", nu, exp_up(s, d));
                    chk("R4 dn", nd, exp_dn(s, d));
                end
                chk("R7 monfb on", nmf, HI);
                chk("R7 monref on", nmr, HI);
            end
        end

        // R6 monitor routing, polarity 0
        wr(1'b0, w0(0, 1));
        repeat (2) @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        chk("R6 monref carries ref", mon_ref, 1);
        chk("R6 monfb idle", mon_fb, 0);
        // R5 polarity write during a pulse is deferred
        chk("R5 dn pulse running", pump_dn, 1);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = w0(1, 1);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 dn held old sense", pump_dn, 1);
        chk("R5 no up", pump_up, 0);
        chk("R5 monref unswapped", mon_ref, 1);
        fb_in = 1'b1;
        @(negedge clk);
        chk("R5 up cleared", pump_up, 0);
        chk("R5 dn cleared", pump_dn, 0);
        fb_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 monfb carries ref swapped", mon_fb, 1);
        chk("R6 monref swapped", mon_ref, 0);
        chk("R5 no spurious up", pump_up, 0);
        chk("R5 no spurious dn", pump_dn, 0);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);

        // R10 R11 lock in state 01, polarity 0
        wr(1'b0, w0(0, 1));
        repeat (2) @(negedge clk);
        run_period(4, nu, nd, nmf, nmr);
        chk("R11 lock cleared", lock, 0);
        for (int k = 1; k <= LCK; k++) begin
            run_period(1, nu, nd, nmf, nmr);
            chk("R10 lock count", lock, (k == LCK) ? 1 : 0);
        end
        run_period(-3, nu, nd, nmf, nmr);
        chk("R11 lead wide unlock", lock, 0);
        for (int k = 1; k <= LCK; k++) run_period(-1, nu, nd, nmf, nmr);
        chk("R10 relock", lock, 1);
        run_period(3, nu, nd, nmf, nmr);
        chk("R11 lag wide unlock", lock, 0);

        // R9 hand-off state
        wr(1'b0, w0(0, 2));
        repeat (2) @(negedge clk);
        for (int k = 1; k <= LCK + 1; k++) begin
            run_period(1, nu, nd, nmf, nmr);
            chk("R9 dn before/after lock", nd, (k < LCK) ? 1 : 0);
        end
        chk("R9 locked", lock, 1);
        chk("R9 monitors on", nmf, HI);
        run_period(3, nu, nd, nmf, nmr);
        chk("R9 wide pulse gated", nd, 0);
        chk("R11 unlocked", lock, 0);
        run_period(1, nu, nd, nmf, nmr);
        chk("R9 drives again", nd, 1);

        // R8 detector off
        wr(1'b0, w0(0, 3));
        repeat (2) @(negedge clk);
        run_period(2, nu, nd, nmf, nmr);
        chk("R8 dn off", nd, 0);
        run_period(-2, nu, nd, nmf, nmr);
        chk("R8 up off", nu, 0);
        chk("R8 monitor on", nmr, HI);

        // R12 gain codes and independence of the two words
        for (int g = 0; g < 4; g++) begin
            wr(1'b1, 16'(g << 14) | 16'h3FFF);
            chk("R12 gain code", gain_code, g);
            run_period(2, nu, nd, nmf, nmr);
            chk("R12 state kept after gain write", nd, 0);
        end
        wr(1'b0, w0(0, 1) | 16'hC000);
        chk("R12 gain kept after word0", gain_code, 3);
        run_period(2, nu, nd, nmf, nmr);
        chk("R12 state from word0", nd, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule